// File: doc/BRIEF.md
# Half-Duplex SPI Slave with Command Decoding

This block is the slave end of a half-duplex SPI link. Each frame from the master, framed by an active-low chip select, carries a command byte, then an address byte, then any number of data bytes. The command decides the destination or source of the data phase. The data can go into a master-writable status word or into a 64-byte shared buffer. The data phase can also return buffer contents or a status word. An exchange command stores the incoming bytes in the buffer and sends buffer bytes back in the same data phase.

The block runs entirely on a fast system clock. SCLK, MOSI and chip select pass through two-flop synchronizers, and their edges are detected in the system clock domain. SCLK must be no faster than one eighth of the system clock. The link uses SPI mode 0. A software-side port reads and writes the buffer one 32-bit word at a time, supplies a second status word, and picks which status word the status-read command returns. Two half-select inputs let either buffer half serve as the receive or the send area.

A one-cycle completion pulse reports the command and the byte count of every frame that reached its data phase. This lets the host side follow the register-level handshakes the master runs.

Top module: `spi_hd_slave`

## Requirements
- R1: Command 0x02 stores each complete data byte in the buffer. The bytes go to consecutive byte positions, starting at the offset given by address bits [4:0], inside the receive half. Buffer byte b sits in word b/4 at bits [8*(b%4)+7 : 8*(b%4)].
- R2: Command 0x03 sends buffer bytes on MISO, MSB first, starting at the addressed offset in the send half. MISO changes after SCLK falling edges and is valid at the next rising edge (mode 0).
- R3: Command 0x01 writes data byte k into bits [8k+7:8k] of the master status word for k < 4. Data bytes after the fourth leave it unchanged.
- R4: Command 0x04 returns the status word selected by the readback select: 0 selects the master-written word, 1 selects the software-written word. The bytes go out least significant byte first, and every byte after the fourth is 0x00.
- R5: Command 0x06 sends the buffer byte at each send-half position. It stores the byte received in the same slot at the matching receive-half position.
- R6: Half select 1 maps the matching direction to words 8-15 (byte positions 32-63). Half select 0 maps it to words 0-7. rx_hi_i governs bytes received from MOSI; tx_hi_i governs bytes sent on MISO.
- R7: The byte offset advances by one per data byte and wraps from 31 to 0 within the selected half.
- R8: A command other than 0x01, 0x02, 0x03, 0x04 or 0x06 changes neither the buffer nor the status words. MISO stays low for the whole frame, and no completion pulse follows.
- R9: Chip select going high at any point ends the frame and discards a partly shifted byte. The next frame starts again with a command byte.
- R10: When chip select rises after the data phase of a known command has begun, done_o pulses for exactly one cycle. done_cmd_o then carries the command and done_bytes_o the number of complete data bytes. A frame that ends earlier gives no pulse.
- R11: After reset, MISO is low, done_o is low and both status words are zero.
- R12: MISO is low during the command and address phases of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | SPI clock from the master (asynchronous) |
| mosi_i | input | 1 | Master-to-slave data line |
| cs_n_i | input | 1 | Active-low chip select |
| miso_o | output | 1 | Slave-to-master data line, registered |
| rx_hi_i | input | 1 | Receive area select: 1 = upper half of the buffer |
| tx_hi_i | input | 1 | Send area select: 1 = upper half of the buffer |
| stat_rb_sel_i | input | 1 | Status read source: 0 = master-written, 1 = software-written |
| sw_stat_we_i | input | 1 | Write strobe for the software status word |
| sw_stat_i | input | STAT_W | New value of the software status word |
| mst_stat_o | output | STAT_W | Master-written status word |
| sw_buf_we_i | input | 1 | Software buffer word write strobe |
| sw_buf_addr_i | input | WAW | Software buffer word index |
| sw_buf_wdata_i | input | 32 | Software buffer write data |
| sw_buf_rdata_o | output | 32 | Software buffer read data, one cycle after the address |
| done_o | output | 1 | One-cycle frame completion pulse |
| done_cmd_o | output | 8 | Command of the completed frame |
| done_bytes_o | output | CNT_W | Complete data bytes in that frame |

## Verification
Each buffer command runs with different starting offsets and both half selections. The test starts at offset 3 to cross word boundaries, and at offset 30 to show the wrap stays inside one half rather than running into the other. The status write uses six bytes, and the status read uses both readback sources. This separates a correct byte order and four-byte limit from one that shifts or overruns. The exchange command has its send and receive halves apart, so the returned bytes must be the old contents. Frames with an unknown command, or aborted mid-byte or mid-address, must leave storage and the completion pulse as the requirements state. A normal frame follows directly after each of them to show the state was cleared.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;

  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_WR_BUF  = 8'h02;
  localparam logic [7:0] OP_RD_BUF  = 8'h03;
  localparam logic [7:0] OP_RD_STAT = 8'h04;
  localparam logic [7:0] OP_XCHG    = 8'h06;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DROP = 2'd3
  } phase_e;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_WR_STAT) || (op == OP_WR_BUF) || (op == OP_RD_BUF) ||
           (op == OP_RD_STAT) || (op == OP_XCHG);
  endfunction

  function automatic logic op_buf_write(input logic [7:0] op);
    return (op == OP_WR_BUF) || (op == OP_XCHG);
  endfunction

  function automatic logic op_sends(input logic [7:0] op);
    return (op == OP_RD_BUF) || (op == OP_RD_STAT) || (op == OP_XCHG);
  endfunction

endpackage

// File: rtl/spi_hd_sync.sv
module spi_hd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hd_buf.sv
module spi_hd_buf #(
  parameter  int WORDS = 16,
  localparam int WAW   = $clog2(WORDS),
  localparam int BAW   = WAW + 2
) (
  input  logic           clk,
  input  logic           a_we,
  input  logic [BAW-1:0] a_waddr,
  input  logic [7:0]     a_wdata,
  input  logic [BAW-1:0] a_raddr,
  output logic [7:0]     a_rbyte,
  input  logic           b_we,
  input  logic [WAW-1:0] b_addr,
  input  logic [31:0]    b_wdata,
  output logic [31:0]    b_rdata
);
  logic [31:0] mem [WORDS];
  logic [31:0] a_q;
  logic [1:0]  a_lane;

  // single process, two ports; SPI byte write lands after a same-cycle word write
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_waddr[BAW-1:2]][8*a_waddr[1:0] +: 8] <= a_wdata;
    a_q     <= mem[a_raddr[BAW-1:2]];
    a_lane  <= a_raddr[1:0];
    b_rdata <= mem[b_addr];
  end

  assign a_rbyte = a_q[8*a_lane +: 8];
endmodule

// File: rtl/spi_hd_stat.sv
module spi_hd_stat #(
  parameter  int STAT_BYTES = 4,
  parameter  int CNT_W      = 8,
  localparam int STAT_W     = 8 * STAT_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_we,
  input  logic [CNT_W-1:0]  m_idx,
  input  logic [7:0]        m_data,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_data,
  input  logic              rb_sel,
  input  logic [CNT_W-1:0]  rd_idx,
  output logic [7:0]        rd_byte,
  output logic [STAT_W-1:0] mst_stat
);
  logic [STAT_W-1:0] sw_stat;
  logic [STAT_W-1:0] src;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_stat <= '0;
      sw_stat  <= '0;
    end else begin
      for (int k = 0; k < STAT_BYTES; k++) begin
        if (m_we && (m_idx == CNT_W'(k))) mst_stat[8*k +: 8] <= m_data;
      end
      if (sw_we) sw_stat <= sw_data;
    end
  end

  assign src = rb_sel ? sw_stat : mst_stat;

  always_comb begin
    rd_byte = 8'h00;
    for (int k = 0; k < STAT_BYTES; k++) begin
      if (rd_idx == CNT_W'(k)) rd_byte = src[8*k +: 8];
    end
  end
endmodule

// File: rtl/spi_hd_frame.sv
module spi_hd_frame
  import spi_hd_pkg::*;
#(
  parameter  int HALF_AW = 5,
  parameter  int CNT_W   = 8,
  localparam int BAW     = HALF_AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             mosi_s,
  input  logic             cs_n_s,
  input  logic             rx_hi,
  input  logic             tx_hi,
  output logic             buf_we,
  output logic [BAW-1:0]   buf_waddr,
  output logic [7:0]       buf_wdata,
  output logic [BAW-1:0]   buf_raddr,
  input  logic [7:0]       buf_rbyte,
  output logic             stat_we,
  output logic [CNT_W-1:0] stat_idx,
  output logic [7:0]       stat_wdata,
  output logic [CNT_W-1:0] stat_ridx,
  input  logic [7:0]       stat_rbyte,
  output logic             miso,
  output logic             done,
  output logic [7:0]       done_cmd,
  output logic [CNT_W-1:0] done_bytes
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phase_e             phase;
  logic               sclk_d;
  logic               rise, fall;
  logic [2:0]         bitcnt;
  logic [7:0]         rx_sh;
  logic [7:0]         tx_sh;
  logic [7:0]         cmd;
  logic [HALF_AW-1:0] off;
  logic [CNT_W-1:0]   cnt;
  logic [7:0]         rx_full;
  logic [7:0]         tx_byte;

  assign rise      = sclk_s & ~sclk_d;
  assign fall      = ~sclk_s & sclk_d;
  assign rx_full   = {rx_sh[6:0], mosi_s};
  assign buf_raddr = {tx_hi, off};
  assign stat_ridx = cnt;

  always_comb begin
    if (cmd == OP_RD_STAT)                        tx_byte = stat_rbyte;
    else if (cmd == OP_RD_BUF || cmd == OP_XCHG)  tx_byte = buf_rbyte;
    else                                          tx_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      phase      <= PH_CMD;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      cmd        <= '0;
      off        <= '0;
      cnt        <= '0;
      miso       <= 1'b0;
      done       <= 1'b0;
      done_cmd   <= '0;
      done_bytes <= '0;
      buf_we     <= 1'b0;
      buf_waddr  <= '0;
      buf_wdata  <= '0;
      stat_we    <= 1'b0;
      stat_idx   <= '0;
      stat_wdata <= '0;
    end else begin
      sclk_d  <= sclk_s;
      done    <= 1'b0;
      buf_we  <= 1'b0;
      stat_we <= 1'b0;
      if (cs_n_s) begin
        if (phase == PH_DATA) begin
          done       <= 1'b1;
          done_cmd   <= cmd;
          done_bytes <= cnt;
        end
        phase  <= PH_CMD;
        bitcnt <= '0;
        tx_sh  <= '0;
        miso   <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh  <= rx_full;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            unique case (phase)
              PH_CMD: begin
                cmd   <= rx_full;
                phase <= PH_ADDR;
              end
              PH_ADDR: begin
                off   <= rx_full[HALF_AW-1:0];
                cnt   <= '0;
                phase <= op_known(cmd) ? PH_DATA : PH_DROP;
              end
              PH_DATA: begin
                if (cmd == OP_WR_STAT) begin
                  stat_we    <= 1'b1;
                  stat_idx   <= cnt;
                  stat_wdata <= rx_full;
                end else if (op_buf_write(cmd)) begin
                  buf_we    <= 1'b1;
                  buf_waddr <= {rx_hi, off};
                  buf_wdata <= rx_full;
                end
                off <= off + 1'b1;
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
              end
              PH_DROP: ;
              default: ;
            endcase
          end
        end
        if (fall) begin
          if (phase == PH_DATA && op_sends(cmd)) begin
            if (bitcnt == 3'd0) begin
              tx_sh <= tx_byte;
              miso  <= tx_byte[7];
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              miso  <= tx_sh[6];
            end
          end else begin
            miso <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_hd_slave.sv
module spi_hd_slave #(
  parameter  int WORDS       = 16,
  parameter  int STAT_BYTES  = 4,
  parameter  int CNT_W       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int WAW         = $clog2(WORDS),
  localparam int BAW         = WAW + 2,
  localparam int HALF_AW     = BAW - 1,
  localparam int STAT_W      = 8 * STAT_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              cs_n_i,
  output logic              miso_o,
  input  logic              rx_hi_i,
  input  logic              tx_hi_i,
  input  logic              stat_rb_sel_i,
  input  logic              sw_stat_we_i,
  input  logic [STAT_W-1:0] sw_stat_i,
  output logic [STAT_W-1:0] mst_stat_o,
  input  logic              sw_buf_we_i,
  input  logic [WAW-1:0]    sw_buf_addr_i,
  input  logic [31:0]       sw_buf_wdata_i,
  output logic [31:0]       sw_buf_rdata_o,
  output logic              done_o,
  output logic [7:0]        done_cmd_o,
  output logic [CNT_W-1:0]  done_bytes_o
);
  localparam logic [2:0] SYNC_INIT = 3'b100;

  logic [2:0]       pin_raw;
  logic [2:0]       pin_s;
  logic             buf_we;
  logic [BAW-1:0]   buf_waddr;
  logic [7:0]       buf_wdata;
  logic [BAW-1:0]   buf_raddr;
  logic [7:0]       buf_rbyte;
  logic             stat_we;
  logic [CNT_W-1:0] stat_idx;
  logic [7:0]       stat_wdata;
  logic [CNT_W-1:0] stat_ridx;
  logic [7:0]       stat_rbyte;

  assign pin_raw = {cs_n_i, mosi_i, sclk_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    spi_hd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_INIT[g])) i_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_raw[g]),
      .q   (pin_s[g])
    );
  end

  spi_hd_frame #(.HALF_AW(HALF_AW), .CNT_W(CNT_W)) i_frame (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (pin_s[0]),
    .mosi_s     (pin_s[1]),
    .cs_n_s     (pin_s[2]),
    .rx_hi      (rx_hi_i),
    .tx_hi      (tx_hi_i),
    .buf_we     (buf_we),
    .buf_waddr  (buf_waddr),
    .buf_wdata  (buf_wdata),
    .buf_raddr  (buf_raddr),
    .buf_rbyte  (buf_rbyte),
    .stat_we    (stat_we),
    .stat_idx   (stat_idx),
    .stat_wdata (stat_wdata),
    .stat_ridx  (stat_ridx),
    .stat_rbyte (stat_rbyte),
    .miso       (miso_o),
    .done       (done_o),
    .done_cmd   (done_cmd_o),
    .done_bytes (done_bytes_o)
  );

  spi_hd_buf #(.WORDS(WORDS)) i_buf (
    .clk     (clk),
    .a_we    (buf_we),
    .a_waddr (buf_waddr),
    .a_wdata (buf_wdata),
    .a_raddr (buf_raddr),
    .a_rbyte (buf_rbyte),
    .b_we    (sw_buf_we_i),
    .b_addr  (sw_buf_addr_i),
    .b_wdata (sw_buf_wdata_i),
    .b_rdata (sw_buf_rdata_o)
  );

  spi_hd_stat #(.STAT_BYTES(STAT_BYTES), .CNT_W(CNT_W)) i_stat (
    .clk      (clk),
    .rst      (rst),
    .m_we     (stat_we),
    .m_idx    (stat_idx),
    .m_data   (stat_wdata),
    .sw_we    (sw_stat_we_i),
    .sw_data  (sw_stat_i),
    .rb_sel   (stat_rb_sel_i),
    .rd_idx   (stat_ridx),
    .rd_byte  (stat_rbyte),
    .mst_stat (mst_stat_o)
  );
endmodule

// File: rtl/spi_hd_slave_chk.sv
module spi_hd_slave_chk #(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_i,
  input logic              miso_o,
  input logic              done_o,
  input logic [STAT_W-1:0] mst_stat_o
);
  logic [2:0] cs_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !cs_n_i)         cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 3'd1;
  end

  assert_reset_state_R11: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && !miso_o && mst_stat_o == '0));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_after_cs_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cs_hi_cnt != 3'd0);

  assert_miso_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_hi_cnt == 3'd7) |-> !miso_o);

  assert_stat_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_hi_cnt == 3'd7 && $past(cs_hi_cnt) == 3'd7) |-> $stable(mst_stat_o));
endmodule

bind spi_hd_slave spi_hd_slave_chk #(.STAT_W(STAT_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n_i     (cs_n_i),
  .miso_o     (miso_o),
  .done_o     (done_o),
  .mst_stat_o (mst_stat_o)
);

// File: tb/test_spi_hd_slave.sv
module test_spi_hd_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        sclk, mosi, cs_n;
  logic        miso;
  logic        rx_hi, tx_hi, rb_sel;
  logic        sw_stat_we;
  logic [31:0] sw_stat;
  logic [31:0] mst_stat;
  logic        sw_we;
  logic [3:0]  sw_addr;
  logic [31:0] sw_wdata, sw_rdata;
  logic        done;
  logic [7:0]  done_cmd;
  logic [7:0]  done_bytes;

  logic [7:0] mo [64];
  logic [7:0] mi [64];
  logic [7:0] model [64];

  int n_chk  = 0;
  int n_fail = 0;
  int done_n = 0;
  int idle_bad = 0;
  int any_hi = 0;
  logic [7:0] last_cmd, last_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hd_slave i_spi_hd_slave (
    .clk(clk), .rst(rst), .sclk_i(sclk), .mosi_i(mosi), .cs_n_i(cs_n),
    .miso_o(miso), .rx_hi_i(rx_hi), .tx_hi_i(tx_hi), .stat_rb_sel_i(rb_sel),
    .sw_stat_we_i(sw_stat_we), .sw_stat_i(sw_stat), .mst_stat_o(mst_stat),
    .sw_buf_we_i(sw_we), .sw_buf_addr_i(sw_addr), .sw_buf_wdata_i(sw_wdata),
    .sw_buf_rdata_o(sw_rdata), .done_o(done), .done_cmd_o(done_cmd),
    .done_bytes_o(done_bytes)
  );

  always @(negedge clk) begin
    if (done) begin
      done_n++;
      last_cmd   = done_cmd;
      last_bytes = done_bytes;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input int w);
    return {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]};
  endfunction

  task automatic sw_wr(input int w, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = 4'(w); sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_rd(input int w, output logic [31:0] d);
    @(negedge clk);
    sw_addr = 4'(w);
    @(negedge clk);
    d = sw_rdata;
  endtask

  // stop_bits > 0 ends the frame after that many SCLK cycles
  task automatic spi_frame(input logic [7:0] c, input logic [7:0] a, input int n,
                           input int stop_bits);
    int total;
    total = (stop_bits > 0) ? stop_bits : 16 + 8 * n;
    done_n = 0; idle_bad = 0; any_hi = 0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < total; k++) begin
      int bi, bt;
      logic [7:0] b;
      bi = k / 8; bt = 7 - (k % 8);
      b = (bi == 0) ? c : (bi == 1) ? a : mo[bi-2];
      mosi = b[bt];
      repeat (HALF) @(negedge clk);
      if (miso !== 1'b0) any_hi++;
      if (bi < 2) begin
        if (miso !== 1'b0) idle_bad++;
      end else begin
        mi[bi-2][bt] = miso;
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 miso low in cmd/addr", 32'(idle_bad), 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 miso after reset", 32'(miso), 32'd0);
    chk("R11 done after reset", 32'(done), 32'd0);
    chk("R11 master status after reset", mst_stat, 32'd0);
  endtask

  task automatic t_preload;
    for (int i = 0; i < 64; i++) model[i] = 8'(i * 7 + 3);
    for (int w = 0; w < 16; w++) sw_wr(w, mword(w));
  endtask

  task automatic t_buf_write;
    logic [31:0] d;
    rx_hi = 1'b0;
    for (int i = 0; i < 6; i++) begin
      mo[i] = 8'hC0 + 8'(i);
      model[3 + i] = mo[i];
    end
    spi_frame(8'h02, 8'hE3, 6, 0);  // address bits above [4:0] ignored
    for (int w = 0; w < 3; w++) begin
      sw_rd(w, d);
      chk("R1 buffer word after write", d, mword(w));
    end
    chk("R10 done count", 32'(done_n), 32'd1);
    chk("R10 done command", 32'(last_cmd), 32'h02);
    chk("R10 done bytes", 32'(last_bytes), 32'd6);
  endtask

  task automatic t_buf_read;
    tx_hi = 1'b0;
    for (int i = 0; i < 5; i++) mo[i] = 8'hFF;
    spi_frame(8'h03, 8'h09, 5, 0);
    for (int i = 0; i < 5; i++) chk("R2 buffer byte on MISO", 32'(mi[i]), 32'(model[9 + i]));
  endtask

  task automatic t_status;
    for (int i = 0; i < 6; i++) mo[i] = 8'hA0 + 8'(i);
    spi_frame(8'h01, 8'h00, 6, 0);
    chk("R3 master status word", mst_stat, 32'hA3A2A1A0);
    rb_sel = 1'b0;
    spi_frame(8'h04, 8'h00, 6, 0);
    for (int i = 0; i < 4; i++) chk("R4 master status readback", 32'(mi[i]), 32'hA0 + 32'(i));
    chk("R4 byte past status", 32'(mi[4]), 32'h00);
    @(negedge clk);
    sw_stat_we = 1'b1; sw_stat = 32'h44332211;
    @(negedge clk);
    sw_stat_we = 1'b0;
    rb_sel = 1'b1;
    spi_frame(8'h04, 8'h00, 5, 0);
    chk("R4 sw status byte0", 32'(mi[0]), 32'h11);
    chk("R4 sw status byte3", 32'(mi[3]), 32'h44);
    chk("R4 sw byte past status", 32'(mi[4]), 32'h00);
    chk("R3 master status kept", mst_stat, 32'hA3A2A1A0);
  endtask

  task automatic t_halves;
    logic [31:0] d;
    rx_hi = 1'b1;
    for (int i = 0; i < 3; i++) begin
      mo[i] = 8'h50 + 8'(i);
      model[32 + i] = mo[i];
    end
    spi_frame(8'h02, 8'h00, 3, 0);
    sw_rd(8, d);
    chk("R6 upper half receive word 8", d, mword(8));
    sw_rd(0, d);
    chk("R6 lower half untouched word 0", d, mword(0));
    tx_hi = 1'b1;
    spi_frame(8'h03, 8'h01, 3, 0);
    for (int i = 0; i < 3; i++) chk("R6 upper half send", 32'(mi[i]), 32'(model[33 + i]));
    rx_hi = 1'b0; tx_hi = 1'b0;
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    rx_hi = 1'b0;
    for (int i = 0; i < 4; i++) mo[i] = 8'h70 + 8'(i);
    model[30] = mo[0]; model[31] = mo[1]; model[0] = mo[2]; model[1] = mo[3];
    spi_frame(8'h02, 8'h1E, 4, 0);
    sw_rd(7, d);
    chk("R7 wrap tail word 7", d, mword(7));
    sw_rd(0, d);
    chk("R7 wrap head word 0", d, mword(0));
    sw_rd(8, d);
    chk("R7 upper half not reached", d, mword(8));
  endtask

  task automatic t_xchg;
    logic [31:0] d;
    logic [7:0] old [4];
    rx_hi = 1'b0; tx_hi = 1'b1;
    for (int i = 0; i < 4; i++) begin
      old[i] = model[36 + i];
      mo[i] = 8'h90 + 8'(i);
      model[4 + i] = mo[i];
    end
    spi_frame(8'h06, 8'h04, 4, 0);
    for (int i = 0; i < 4; i++) chk("R5 exchange sends old bytes", 32'(mi[i]), 32'(old[i]));
    sw_rd(1, d);
    chk("R5 exchange stores received bytes", d, mword(1));
    chk("R10 exchange done command", 32'(last_cmd), 32'h06);
    chk("R10 exchange done bytes", 32'(last_bytes), 32'd4);
    tx_hi = 1'b0;
  endtask

  task automatic t_unknown;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) mo[i] = 8'hFF;
    spi_frame(8'h05, 8'h00, 4, 0);
    chk("R8 miso low all frame", 32'(any_hi), 32'd0);
    chk("R8 no done pulse", 32'(done_n), 32'd0);
    sw_rd(0, d);
    chk("R8 buffer unchanged", d, mword(0));
    chk("R8 status unchanged", mst_stat, 32'hA3A2A1A0);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    rx_hi = 1'b0; tx_hi = 1'b0;
    mo[0] = 8'h11; mo[1] = 8'h22; mo[2] = 8'h33;
    model[16] = 8'h11; model[17] = 8'h22;
    spi_frame(8'h02, 8'h10, 3, 16 + 16 + 3);
    sw_rd(4, d);
    chk("R9 partial byte discarded", d, mword(4));
    chk("R10 aborted data frame done", 32'(done_n), 32'd1);
    chk("R10 aborted frame byte count", 32'(last_bytes), 32'd2);
    spi_frame(8'h03, 8'h10, 0, 12);
    chk("R10 no done before data phase", 32'(done_n), 32'd0);
    spi_frame(8'h03, 8'h10, 3, 0);
    for (int i = 0; i < 3; i++) chk("R9 fresh frame after abort", 32'(mi[i]), 32'(model[16 + i]));
  endtask

  initial begin
    rst = 1'b1; sclk = 1'b0; mosi = 1'b0; cs_n = 1'b1;
    rx_hi = 1'b0; tx_hi = 1'b0; rb_sel = 1'b0;
    sw_stat_we = 1'b0; sw_stat = '0; sw_we = 1'b0; sw_addr = '0; sw_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_preload();
    t_buf_write();
    t_buf_read();
    t_status();
    t_halves();
    t_wrap();
    t_xchg();
    t_unknown();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule